// File: doc/BRIEF.md
# Multiplier-free FIR filter using distributed arithmetic

This block is a fixed-coefficient FIR filter with no multipliers. Each accepted sample is pushed into a short delay line. The block then walks through the bit positions of all stored samples, starting at the least significant bit. At each position it gathers the bit from every tap into an address. That address selects a constant table entry holding the sum of the coefficients whose taps have a set bit. The entry is shifted to the weight of its bit position and added into an accumulator. The most significant plane is the two's complement sign plane, so its entry is subtracted instead of added.

The coefficient table is built at elaboration from a packed coefficient parameter. Entry k of the table is the sum of the coefficients whose tap index has a 1 in k. The parameter `BPC` selects how many bit planes are handled per clock, either one or two. With two, two table lookups run side by side, the sample rate doubles, and the table logic roughly doubles with it.

The block takes a new sample only while `ready` is high. Each sample produces exactly one result, marked by a single-cycle `out_valid` pulse.

Top module: `da_fir`

## Requirements
- R1: After reset, `ready` is 1, `out_valid` is 0, `out_data` is 0, and every delay-line tap holds 0.
- R2: A sample is taken only at a clock edge where `in_valid` and `ready` are both 1. Any `in_valid` seen while `ready` is 0 has no effect on the delay line or on any later result.
- R3: Samples and coefficients are signed two's complement. Tap 0 holds the newest sample, and tap t uses coefficient field `COEFS[t*COEF_W +: COEF_W]`. Each result equals the sum over t of coefficient t times tap t, taken after the new sample has been shifted in.
- R4: `out_valid` goes high exactly DATA_W/BPC clock edges after the accepting edge and stays high for exactly one cycle.
- R5: `ready` goes low at the accepting edge and returns high at the same edge that raises `out_valid`. A new sample may therefore be presented in the cycle where `out_valid` is high.
- R6: The sign bit plane is given negative weight, so the results are exact at the extremes of the input range (all taps at -2^(DATA_W-1), or all taps at 2^(DATA_W-1)-1). The DATA_W+COEF_W+clog2(TAPS)-bit output never wraps.
- R7: `out_data` keeps its value in every cycle where `out_valid` is 0.
- R8: With BPC=2, the upper plane of each pair carries one more bit of weight than the lower plane. Results are identical to BPC=1, and the latency is DATA_W/2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A new sample is presented on `in_data` |
| in_data | input | DATA_W | Signed sample |
| ready | output | 1 | High while the block is idle and can take a sample |
| out_valid | output | 1 | One-cycle strobe: `out_data` holds a new result |
| out_data | output | DATA_W+COEF_W+clog2(TAPS) | Signed filter output |

## Verification
A fault in the bit counter shows up at the ports on the very first sample. Either `out_valid` arrives on the wrong cycle, or one bit plane is skipped or counted twice and the result is wrong. A delay line that moves while the block is busy corrupts the next result and every result after it, because the bad tap value stays in the line for TAPS samples. A sign plane with the wrong sign is hidden while samples are small and positive. It appears as soon as a negative sample enters, which is why the bench drives runs at both ends of the input range. A behavioural model is compared with `ready`, `out_valid` and `out_data` on every clock, so each of these faults is reported on the first cycle where it is visible.

// File: rtl/da_fir.sv
module da_fir #(
  parameter int TAPS   = 4,
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int BPC    = 1,
  parameter logic [TAPS*COEF_W-1:0] COEFS = 32'hFE07FB03,
  localparam int ACC_W = DATA_W + COEF_W + $clog2(TAPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              ready,
  output logic              out_valid,
  output logic [ACC_W-1:0]  out_data
);

  localparam int STEPS = DATA_W / BPC;
  localparam int CW    = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam int BW    = $clog2(DATA_W);
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  initial assert (BPC >= 1 && BPC <= 2 && DATA_W % BPC == 0)
    else $error("da_fir: BPC must be 1 or 2 and divide DATA_W");

  function automatic logic signed [ACC_W-1:0] subset_sum(int k);
    logic signed [ACC_W-1:0] s;
    logic [COEF_W-1:0] c;
    s = '0;
    for (int t = 0; t < TAPS; t++) begin
      c = COEFS[t*COEF_W +: COEF_W];
      if (k[t]) s = s + {{(ACC_W-COEF_W){c[COEF_W-1]}}, c};
    end
    return s;
  endfunction

  logic signed [ACC_W-1:0] tbl [1<<TAPS];
  for (genvar k = 0; k < (1 << TAPS); k++) begin : g_tbl
    assign tbl[k] = subset_sum(k);
  end

  logic [DATA_W-1:0]       line_q [TAPS];
  logic                    busy;
  logic [CW-1:0]           cnt;
  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] psum;
  logic signed [ACC_W-1:0] tm;
  logic [TAPS-1:0]         addr;
  logic [BW-1:0]           bi;

  assign ready = !busy;

  always_comb begin
    psum = '0;
    tm   = '0;
    addr = '0;
    bi   = '0;
    for (int j = 0; j < BPC; j++) begin
      bi = BW'(int'(cnt) * BPC + j);
      for (int t = 0; t < TAPS; t++) addr[t] = line_q[t][bi];
      tm = tbl[addr] <<< bi;
      if (bi == BW'(DATA_W - 1)) tm = -tm;
      psum = psum + tm;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      for (int t = 0; t < TAPS; t++) line_q[t] <= '0;
    end else begin
      out_valid <= 1'b0;
      if (!busy) begin
        if (in_valid) begin
          line_q[0] <= in_data;
          for (int t = 1; t < TAPS; t++) line_q[t] <= line_q[t-1];
          acc  <= '0;
          cnt  <= '0;
          busy <= 1'b1;
        end
      end else if (cnt == LAST) begin
        out_data  <= acc + psum;
        out_valid <= 1'b1;
        busy      <= 1'b0;
        cnt       <= '0;
      end else begin
        acc <= acc + psum;
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_idle_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cnt == '0);

  assert_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && in_valid) |=> !ready);

  assert_done_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ready);

  assert_ignore_head_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> $stable(line_q[0]));

  assert_ignore_tail_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> $stable(line_q[TAPS-1]));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

endmodule

// File: tb/test_da_fir.sv
`timescale 1ns/1ps
module test_da_fir;

  localparam int N = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       iv [2];
  logic [7:0] id [2];
  logic       rdy [2];
  logic       ov [2];
  logic [17:0] od [2];

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  da_fir #(.BPC(1)) i_da_fir (
    .clk(clk), .rst_n(rst_n), .in_valid(iv[0]), .in_data(id[0]),
    .ready(rdy[0]), .out_valid(ov[0]), .out_data(od[0]));

  da_fir #(.BPC(2)) i_da_fir_2 (
    .clk(clk), .rst_n(rst_n), .in_valid(iv[1]), .in_data(id[1]),
    .ready(rdy[1]), .out_valid(ov[1]), .out_data(od[1]));

  int coef [4] = '{3, -5, 7, -2};
  int steps [2] = '{8, 4};
  int hist [2][4];
  bit m_busy [2];
  int m_cnt [2];
  bit m_valid [2];
  int m_out [2];
  int n_out [2];
  bit m_ext [2];

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] samp(int i);
    case (i)
      0: return 8'd1;
      1: return 8'hFF;
      2: return 8'd127;
      3, 4, 5, 6: return 8'h80;
      7, 8, 9, 10: return 8'h7F;
      default: return 8'((i * 73 + 19) ^ (i * 11));
    endcase
  endfunction

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (!rst_n) begin
        for (int t = 0; t < 4; t++) hist[k][t] = 0;
        m_busy[k] = 0; m_cnt[k] = 0; m_valid[k] = 0; m_out[k] = 0; n_out[k] = 0; m_ext[k] = 0;
      end else begin
        m_valid[k] = 0;
        if (m_busy[k]) begin
          m_cnt[k]++;
          if (m_cnt[k] == steps[k]) begin
            int s;
            s = 0;
            m_ext[k] = 1;
            for (int t = 0; t < 4; t++) begin
              s += coef[t] * hist[k][t];
              if (hist[k][t] != -128 && hist[k][t] != 127) m_ext[k] = 0;
            end
            m_busy[k] = 0; m_valid[k] = 1; m_out[k] = s; n_out[k]++;
          end
        end else if (iv[k]) begin
          for (int t = 3; t > 0; t--) hist[k][t] = hist[k][t-1];
          hist[k][0] = int'($signed(id[k]));
          m_busy[k] = 1; m_cnt[k] = 0;
        end
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int k = 0; k < 2; k++) begin
        chk(rdy[k] == !m_busy[k], k ? "R5 R8 ready" : "R5 ready", int'(rdy[k]), int'(!m_busy[k]));
        chk(ov[k] == m_valid[k], k ? "R4 R8 out_valid" : "R4 out_valid", int'(ov[k]), int'(m_valid[k]));
        chk(int'($signed(od[k])) == m_out[k],
            !m_valid[k] ? "R7 out_data hold" :
            (m_ext[k] ? "R6 extreme out_data" : (k ? "R3 R8 R2 out_data" : "R3 R2 out_data")),
            int'($signed(od[k])), m_out[k]);
      end
    end
  end

  task automatic drive(int k);
    int i = 0;
    int cyc = 0;
    while (i < N) begin
      @(negedge clk);
      cyc++;
      if (rdy[k]) begin
        if (cyc % 7 == 3) iv[k] = 1'b0;
        else begin
          iv[k] = 1'b1;
          id[k] = samp(i);
          i++;
        end
      end else begin
        iv[k] = (cyc % 3 == 0);
        id[k] = 8'h5A ^ 8'(cyc);
      end
    end
    @(negedge clk);
    iv[k] = 1'b0;
  endtask

  initial begin
    iv[0] = 1'b0; iv[1] = 1'b0; id[0] = 8'h00; id[1] = 8'h00;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      chk(rdy[k] == 1'b1, "R1 ready after reset", int'(rdy[k]), 1);
      chk(ov[k] == 1'b0, "R1 out_valid after reset", int'(ov[k]), 0);
      chk(od[k] == '0, "R1 out_data after reset", int'(od[k]), 0);
    end
    rst_n = 1'b1;
    fork
      drive(0);
      drive(1);
    join
    repeat (20) @(negedge clk);
    for (int k = 0; k < 2; k++)
      chk(n_out[k] == N, "R3 result count", n_out[k], N);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule